// File: doc/BRIEF.md
# One-Hot Rising-Edge Event Counter

This block counts low-to-high transitions on a single asynchronous data line, such as a pushbutton, and keeps the running count as a one-hot code. By default the code is 7 bits wide. Each output bit drives one segment of a seven-segment display, so exactly one segment is lit at any time, and the lit segment moves one place for every detected edge.

The raw input first passes through a flop-chain synchronizer. An edge detector then compares the synchronized level with its value one cycle earlier and raises a single-cycle pulse when the level has gone from 0 to 1. That pulse rotates the active bit toward the higher index. The block does no debouncing: every bounce that survives sampling is counted, so one press on a noisy switch can move the display several places.

Top module: `pulse_ring_counter`

## Requirements
- R1: `seg_o` always holds exactly one set bit after reset, and bit k of `seg_o` drives segment k directly.
- R2: Each 0-to-1 transition of `din` moves the set bit exactly one position toward the higher index. The output changes after the third rising clock edge that follows the first clock edge at which `din` is sampled high. At the first and second of those edges the output keeps its old value.
- R3: Reset (`rst`) is synchronous and active-high. It sets `seg_o` to 7'b0000001, so bit 0 is active.
- R4: When bit 6 is active, the next detected edge makes bit 0 active again.
- R5: A falling transition of `din`, or `din` held at a steady level for any number of cycles, leaves `seg_o` unchanged.
- R6: Every separate high pulse on `din` counts as its own edge, which means bounces are counted. This holds when each high and each low phase lasts at least two clock cycles. N such pulses advance the set bit by N positions, modulo 7.
- R7: If reset and a detected edge fall in the same cycle, reset wins and `seg_o` becomes 7'b0000001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Asynchronous data line whose rising edges are counted |
| seg_o | output | 7 | One-hot count; each bit drives one display segment |

## Verification
Two functions can land in the same clock cycle: the synchronous reset and the advance caused by a detected edge. The bench raises `din`, waits until the edge pulse is due on the next clock, and asserts `rst` so that it lands on that same clock edge. It then expects `seg_o` to read 7'b0000001 and to stay there once `din` returns low and reset is released. A plain edge-pulse assertion covers the normal case. A separate reset assertion confirms that reset also wins in the coincident case.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int unsigned PRC_RING_W = 7;
  localparam int unsigned PRC_SYNC_N = 2;

  // Code loaded by reset: lowest position active.
  function automatic logic [PRC_RING_W-1:0] prc_home();
    logic [PRC_RING_W-1:0] v;
    v = '0;
    v[0] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/prc_sync.sv
module prc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain;

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[N-1];
endmodule

// File: rtl/prc_rise.sv
module prc_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // A detected edge lasts a single cycle; R6
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R6
endmodule

// File: rtl/prc_ring.sv
module prc_ring #(
  parameter int unsigned WIDTH = prc_pkg::PRC_RING_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [WIDTH-1:0] ring
);
  function automatic logic [WIDTH-1:0] rot_up(input logic [WIDTH-1:0] v);
    return {v[WIDTH-2:0], v[WIDTH-1]};
  endfunction

  logic [WIDTH-1:0] home;
  assign home = {{(WIDTH-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       ring <= home;
    else if (step) ring <= rot_up(ring);
  end

  AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(ring) == 1); // R1
  AST_RING_STEP: assert property (@(posedge clk) disable iff (rst)
    step |=> ring == rot_up($past(ring))); // R2
  AST_RING_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(ring)); // R5
  AST_RING_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && ring[WIDTH-1]) |=> ring[0]); // R4
endmodule

// File: rtl/pulse_ring_counter.sv
module pulse_ring_counter #(
  parameter int unsigned RING_W = prc_pkg::PRC_RING_W,
  parameter int unsigned SYNC_N = prc_pkg::PRC_SYNC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  output logic [RING_W-1:0] seg_o
);
  logic din_s;
  logic edge_hit;

  prc_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d_async(din), .d_sync(din_s)
  );

  prc_rise u_rise (
    .clk(clk), .rst(rst), .lvl(din_s), .rise(edge_hit)
  );

  prc_ring #(.WIDTH(RING_W)) u_ring (
    .clk(clk), .rst(rst), .step(edge_hit), .ring(seg_o)
  );

  // Reset wins over anything, including a coincident edge; R3 and R7
  AST_RESET_HOME: assert property (@(posedge clk)
    rst |=> seg_o == {{(RING_W-1){1'b0}}, 1'b1}); // R3
  AST_RESET_OVER_EDGE: assert property (@(posedge clk)
    (rst && edge_hit) |=> seg_o[0]); // R7
endmodule

// File: tb/pulse_ring_counter_bench.sv
`timescale 1ns/1ps
module pulse_ring_counter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [6:0] seg_o;
  int checks = 0;
  int errors = 0;
  int pos = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_ring_counter u_pulse_ring_counter (
    .clk(clk), .rst(rst), .din(din), .seg_o(seg_o)
  );

  function automatic logic [6:0] code_of(input int p);
    return 7'(1 << (p % 7));
  endfunction

  task automatic chk(input string tag, input logic [6:0] exp);
    checks++;
    if (seg_o !== exp) begin
      errors++;
      $display("FAIL %s: seg_o=%b expected=%b", tag, seg_o, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    din = 1'b1; wait_n(hi);
    din = 1'b0; wait_n(lo);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: expired expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    chk("R3 reset state", 7'b0000001);

    // R2 latency: unchanged after two clock edges, advanced after the third
    din = 1'b1;
    wait_n(2);
    chk("R2 no change before third edge", code_of(0));
    wait_n(1);
    pos = 1;
    chk("R2 advance on third edge", code_of(pos));
    // R5 steady high
    wait_n(10);
    chk("R5 steady high", code_of(pos));
    din = 1'b0;
    wait_n(10);
    chk("R5 falling edge / steady low", code_of(pos));

    // R2/R4/R1 sweep: single edges through two full wraps
    for (int k = 0; k < 15; k++) begin
      pulse(3, 3);
      pos++;
      chk((pos % 7 == 0) ? "R4 wrap to bit 0" : "R2 R1 single step", code_of(pos));
    end

    // R6 bursts of bounces with minimum phases
    for (int n = 1; n <= 9; n++) begin
      for (int b = 0; b < n; b++) pulse(2, 2);
      wait_n(3);
      pos += n;
      chk("R6 bounce burst", code_of(pos));
    end

    // R7 reset coincident with edge pulse
    din = 1'b1;
    wait_n(2);
    rst = 1'b1;
    wait_n(1);
    chk("R7 reset beats edge", 7'b0000001);
    din = 1'b0;
    rst = 1'b0;
    wait_n(6);
    pos = 0;
    chk("R7 stays home after release", code_of(pos));

    // R3 reset mid-count
    pulse(3, 3); pulse(3, 3);
    pos = 2;
    chk("R2 count after R7", code_of(pos));
    rst = 1'b1; wait_n(1); rst = 1'b0; wait_n(1);
    pos = 0;
    chk("R3 reset mid count", code_of(pos));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule